// File: doc/BRIEF.md
# Flash Write-Status Reporter

This block models, clock by clock, the status logic that a byte-wide parallel flash device presents while an internal write is running. A command decoder elsewhere raises a one-clock start pulse together with the kind of operation (byte program, sector erase or chip erase) and, for a program, the byte being stored. The block then holds a busy flag for a fixed number of clocks set by a parameter for each operation kind. Program time and erase time never depend on how many writes the device has already seen.

While busy, every read returns a status byte instead of array contents. Bit 7 gives the inverted top bit of the byte being programmed, or a constant 0 during any erase. Bit 6 changes on every read strobe, and the first read after a start shows 1. All other bits read 0. Once the timer runs out, bit 6 stops changing and reads pass the array data from the storage input straight through. During an erase that means bit 7 reads 1, because erased cells hold all ones.

Top module: `flash_status_engine`

## Requirements
- R1: Operation code 0 is byte program, 1 is sector erase and 2 is chip erase. An accepted start sets `busy` in the clock after the start pulse is sampled. `busy` then stays high for exactly PROG_CYCLES, SECTOR_ERASE_CYCLES or CHIP_ERASE_CYCLES clocks, matching the code.
- R2: While a byte program is busy, bit 7 of `readData` is the complement of bit 7 of the program byte that was captured at start.
- R3: While a sector or chip erase is busy, bit 7 of `readData` is 0.
- R4: While busy, bit 6 of `readData` is 1 on the first read after the start and inverts after every read strobe. Clocks without a read strobe leave it unchanged.
- R5: While busy, bits 5 to 0 of `readData` are 0.
- R6: While not busy, including after reset, `readData` equals `arrayData`, and repeated reads return the same value.
- R7: A start pulse that arrives while busy is ignored. It does not change the remaining time or the reported bit 7.
- R8: Operation code 3 is reserved. A start pulse with that code leaves `busy` low.
- R9: Bit 7 of the program byte is captured only at start. Later changes on `progData` do not affect the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-clock request to begin an internal operation |
| opKind | input | 2 | Operation code (0 program, 1 sector erase, 2 chip erase, 3 reserved) |
| progData | input | 8 | Byte being programmed, sampled with the start pulse |
| readStrobe | input | 1 | One clock per read access |
| arrayData | input | 8 | True stored data for the addressed location |
| readData | output | 8 | Status byte while busy, array data otherwise |
| busy | output | 1 | High while the internal operation runs |

## Verification
The assertions assume that `startPulse` and `readStrobe` are clean, synchronous, single-clock strobes. They also assume that the three duration parameters are at least one, so every accepted start produces at least one busy clock in which the first-read rule can be observed. The stimulus changes every input only on the falling clock edge, holds each strobe for exactly one clock, and uses only the operation codes named in R1 and R8. The bench samples each read in the same half cycle in which the strobe is high, before the edge that advances the toggle.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM = 2'd0,
    OP_SECTOR  = 2'd1,
    OP_CHIP    = 2'd2,
    OP_NONE    = 2'd3
  } opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;   // a start was taken this clock
    logic advance;  // a read strobe arrived while busy
  } ctrlStrobes_t;

endpackage

// File: rtl/status_ctrl.sv
module status_ctrl
  import flash_status_pkg::*;
#(
  parameter int PROG_CYCLES         = 20,
  parameter int SECTOR_ERASE_CYCLES = 60,
  parameter int CHIP_ERASE_CYCLES   = 150
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic [1:0]   opKind,
  input  logic         readStrobe,
  output logic         busy,
  output ctrlStrobes_t strobes
);

  localparam int MAX_A   = (PROG_CYCLES > SECTOR_ERASE_CYCLES) ? PROG_CYCLES : SECTOR_ERASE_CYCLES;
  localparam int MAX_CYC = (MAX_A > CHIP_ERASE_CYCLES) ? MAX_A : CHIP_ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] remaining;
  logic             kindValid;

  assign kindValid       = (opKind_e'(opKind) != OP_NONE);
  assign strobes.accept  = startPulse && !busy && kindValid;
  assign strobes.advance = readStrobe && busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      remaining <= '0;
    end else if (strobes.accept) begin
      busy <= 1'b1;
      case (opKind_e'(opKind))
        OP_PROGRAM: remaining <= CNT_W'(PROG_CYCLES - 1);
        OP_SECTOR:  remaining <= CNT_W'(SECTOR_ERASE_CYCLES - 1);
        default:    remaining <= CNT_W'(CHIP_ERASE_CYCLES - 1);
      endcase
    end else if (busy) begin
      if (remaining == '0) busy <= 1'b0;
      else                 remaining <= remaining - 1'b1;
    end
  end

  // R1: a valid start while idle raises busy next clock
  a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy && opKind != 2'd3) |=> busy);

  // R8: reserved code never starts an operation
  a_r8_reserved_idle: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !busy && opKind == 2'd3) |=> !busy);

  // R1: the timer never holds more than the longest duration
  a_r1_timer_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(remaining) < MAX_CYC));

endmodule

// File: rtl/status_datapath.sv
module status_datapath
  import flash_status_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         busyIn,
  input  logic [1:0]   opKind,
  input  logic [7:0]   progData,
  input  logic         readStrobe,
  input  logic [7:0]   arrayData,
  output logic [7:0]   readData
);

  logic latchedBit7;
  logic eraseMode;
  logic toggleState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchedBit7 <= 1'b0;
      eraseMode   <= 1'b0;
      toggleState <= 1'b0;
    end else if (strobes.accept) begin
      latchedBit7 <= progData[7];
      eraseMode   <= (opKind_e'(opKind) != OP_PROGRAM);
      toggleState <= 1'b0;
    end else if (strobes.advance) begin
      toggleState <= ~toggleState;
    end
  end

  always_comb begin
    if (busyIn) readData = {(eraseMode ? 1'b0 : ~latchedBit7), ~toggleState, 6'b0};
    else        readData = arrayData;
  end

  // R4: first status after start shows bit 6 high
  a_r4_first_read_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyIn) |-> readData[6]);

  // R4: each read strobe while busy inverts bit 6
  a_r4_toggle_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && readStrobe) |=> (!busyIn || (readData[6] != $past(readData[6]))));

  // R4: no strobe, no change
  a_r4_hold_without_read: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && !readStrobe) |=> (!busyIn || $stable(readData[6])));

  // R9: captured program bit stays put for the whole operation
  a_r9_latch_held: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> (!busyIn || $stable(latchedBit7)));

endmodule

// File: rtl/flash_status_engine.sv
module flash_status_engine
  import flash_status_pkg::*;
#(
  parameter int PROG_CYCLES         = 20,
  parameter int SECTOR_ERASE_CYCLES = 60,
  parameter int CHIP_ERASE_CYCLES   = 150
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [1:0] opKind,
  input  logic [7:0] progData,
  input  logic       readStrobe,
  input  logic [7:0] arrayData,
  output logic [7:0] readData,
  output logic       busy
);

  ctrlStrobes_t strobes;

  status_ctrl #(
    .PROG_CYCLES        (PROG_CYCLES),
    .SECTOR_ERASE_CYCLES(SECTOR_ERASE_CYCLES),
    .CHIP_ERASE_CYCLES  (CHIP_ERASE_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .opKind    (opKind),
    .readStrobe(readStrobe),
    .busy      (busy),
    .strobes   (strobes)
  );

  status_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busyIn    (busy),
    .opKind    (opKind),
    .progData  (progData),
    .readStrobe(readStrobe),
    .arrayData (arrayData),
    .readData  (readData)
  );

endmodule

// File: tb/sim_flash_status_engine.sv
`timescale 1ns/1ps
module sim_flash_status_engine;

  localparam int P_CYC = 20;
  localparam int S_CYC = 60;
  localparam int C_CYC = 150;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [1:0] opKind = 2'd0;
  logic [7:0] progData = 8'h00;
  logic       readStrobe = 1'b0;
  logic [7:0] arrayData = 8'h00;
  logic [7:0] readData;
  logic       busy;

  int checks = 0;
  int failures = 0;
  int busyClocks = 0;
  logic countEn = 1'b0;

  always #2.5 clk = ~clk;

  flash_status_engine #(
    .PROG_CYCLES(P_CYC), .SECTOR_ERASE_CYCLES(S_CYC), .CHIP_ERASE_CYCLES(C_CYC)
  ) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .opKind(opKind),
    .progData(progData), .readStrobe(readStrobe), .arrayData(arrayData),
    .readData(readData), .busy(busy)
  );

  always @(negedge clk) if (countEn && busy) busyClocks++;

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic startOp(logic [1:0] kind, logic [7:0] data);
    @(negedge clk);
    busyClocks = 0;
    countEn = 1'b1;
    opKind = kind;
    progData = data;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  // Called at a falling edge; returns the byte seen while strobe is high
  task automatic doRead(output logic [7:0] val);
    readStrobe = 1'b1;
    #1 val = readData;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    countEn = 1'b0;
  endtask

  task automatic testReset();
    arrayData = 8'h96;
    #1;
    chk("R6 reset busy", busy, 0);
    chk("R6 reset passthrough", readData, 8'h96);
  endtask

  task automatic testDuration(logic [1:0] kind, int expCyc);
    startOp(kind, 8'h00);
    waitIdle();
    chk("R1 busy duration", busyClocks, expCyc);
  endtask

  task automatic testProgramHigh();
    logic [7:0] v;
    startOp(2'd0, 8'h5A);
    doRead(v); chk("R2 R4 R5 read1", v, 8'hC0);
    doRead(v); chk("R2 R4 R5 read2", v, 8'h80);
    doRead(v); chk("R4 read3", v, 8'hC0);
    doRead(v); chk("R4 read4", v, 8'h80);
    #1 chk("R4 idle hold a", readData, 8'hC0);
    @(negedge clk); #1 chk("R4 idle hold b", readData, 8'hC0);
    progData = 8'hFF;
    @(negedge clk);
    doRead(v); chk("R9 late progData ignored", v, 8'hC0);
    waitIdle();
    arrayData = 8'h5A;
    doRead(v); chk("R6 after program read1", v, 8'h5A);
    doRead(v); chk("R6 after program read2", v, 8'h5A);
  endtask

  task automatic testProgramLow();
    logic [7:0] v;
    startOp(2'd0, 8'hA5);
    doRead(v); chk("R2 inverted bit7 read1", v, 8'h40);
    doRead(v); chk("R2 inverted bit7 read2", v, 8'h00);
    waitIdle();
  endtask

  task automatic testErase(logic [1:0] kind);
    logic [7:0] v;
    arrayData = 8'h12;
    startOp(kind, 8'h00);
    doRead(v); chk("R3 erase read1", v, 8'h40);
    doRead(v); chk("R3 erase read2", v, 8'h00);
    doRead(v); chk("R3 erase read3", v, 8'h40);
    waitIdle();
    arrayData = 8'hFF;
    doRead(v); chk("R6 erased array", v, 8'hFF);
    doRead(v); chk("R6 erased array again", v, 8'hFF);
  endtask

  task automatic testStartWhileBusy();
    logic [7:0] v;
    startOp(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    opKind = 2'd2;
    progData = 8'hFF;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    doRead(v); chk("R7 bit7 kept from program", v, 8'hC0);
    waitIdle();
    chk("R7 duration unchanged", busyClocks, P_CYC);
  endtask

  task automatic testReserved();
    arrayData = 8'h77;
    startOp(2'd3, 8'h00);
    #1 chk("R8 no busy", busy, 0);
    repeat (2) @(negedge clk);
    #1 chk("R8 still idle", busy, 0);
    chk("R8 passthrough", readData, 8'h77);
    countEn = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testDuration(2'd0, P_CYC);
    testDuration(2'd1, S_CYC);
    testDuration(2'd2, C_CYC);
    testProgramHigh();
    testProgramLow();
    testErase(2'd1);
    testErase(2'd2);
    testStartWhileBusy();
    testReserved();
    finishRun();
  end

endmodule